// File: doc/BRIEF.md
# Multicycle Program Counter Update Unit

This block owns the program counter of a processor that spends several clock cycles on each instruction. Every cycle it picks a candidate next address from one of four sources: the incremented address produced by the shared ALU, the branch target held in the ALU output register, a jump target built from the current PC and the instruction's 26-bit target field, or a fixed exception vector. The sequencer tells it, through two write strobes, whether to load that candidate.

One strobe loads the PC unconditionally. It is used for sequential fetch and for jumps. The other strobe loads the PC only when the ALU reports a zero result, which turns an A−B subtract into a branch-if-equal decision. The block also supplies the branch displacement, formed from the 16-bit immediate, to the ALU operand selector.

Top module: `pc_update_unit`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, the PC becomes 0x00000000 at that edge. The reset is synchronous.
- R2: When `pc_sel` = 2'b00 and a load is enabled, the PC takes `alu_res` at the next rising edge.
- R3: When `pc_sel` = 2'b01 and a load is enabled, the PC takes `alu_out_q` at the next rising edge.
- R4: When `pc_sel` = 2'b10 and a load is enabled, the PC takes the jump target. Its bits [31:28] are the PC's bits [31:28] from before the edge, its bits [27:2] are `jfield`, and its bits [1:0] are zero.
- R5: When `pc_sel` = 2'b11 and a load is enabled, the PC takes the exception vector 0x80000180.
- R6: When `wr_cond` is high and `wr_uncond` is low, the PC loads only if `alu_zero` is high. If `alu_zero` is low, the PC keeps its value.
- R7: When both `wr_uncond` and `wr_cond` are low, the PC keeps its value whatever the other inputs are.
- R8: `br_off` always equals `imm16` sign-extended to 32 bits and multiplied by four, so its two low bits are zero. It is combinational.
- R9: When `wr_uncond` is high, the PC loads even if `wr_cond` is high and `alu_zero` is low. The load enable is the OR of the unconditional strobe with the zero-qualified conditional strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_uncond | input | 1 | Unconditional PC load strobe |
| wr_cond | input | 1 | PC load strobe that takes effect only when `alu_zero` is high |
| alu_zero | input | 1 | ALU zero flag |
| pc_sel | input | 2 | Next-PC source: 00 ALU result, 01 ALU output register, 10 jump, 11 exception vector |
| alu_res | input | 32 | Combinational ALU result (incremented PC) |
| alu_out_q | input | 32 | Registered ALU output (branch target) |
| jfield | input | 26 | Jump target field of the instruction |
| imm16 | input | 16 | Instruction immediate |
| pc | output | 32 | Current program counter |
| br_off | output | 32 | Sign-extended immediate shifted left by two |

## Verification
Two pairs of functions can act in the same cycle. The first pair is the two write strobes. The bench raises the unconditional and the conditional strobe together while `alu_zero` is low, and it expects a load, because the unconditional strobe alone is enough. The second pair is the jump and the PC register that feeds the jump's upper bits. The bench first loads a PC whose top nibble is nonzero and then jumps, and it judges the result by checking that the new top nibble equals the old one and does not come from the inputs.

// File: rtl/pc_update_unit.sv
module pc_update_unit #(
  parameter int unsigned W       = 32,
  parameter int unsigned JW      = 26,
  parameter int unsigned IW      = 16,
  parameter logic [W-1:0] EXC_VEC = 32'h8000_0180
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_uncond,
  input  logic          wr_cond,
  input  logic          alu_zero,
  input  logic [1:0]    pc_sel,
  input  logic [W-1:0]  alu_res,
  input  logic [W-1:0]  alu_out_q,
  input  logic [JW-1:0] jfield,
  input  logic [IW-1:0] imm16,
  output logic [W-1:0]  pc,
  output logic [W-1:0]  br_off
);
  localparam int unsigned HI = W - JW - 2;
  localparam int unsigned EXT = W - IW - 2;

  logic [W-1:0] pc_q, pc_d, jmp_tgt;
  logic         ld;

  assign ld      = wr_uncond | (wr_cond & alu_zero);
  assign jmp_tgt = {pc_q[W-1 -: HI], jfield, 2'b00};
  assign br_off  = {{EXT{imm16[IW-1]}}, imm16, 2'b00};
  assign pc      = pc_q;

  always_comb begin
    case (pc_sel)
      2'b00:   pc_d = alu_res;
      2'b01:   pc_d = alu_out_q;
      2'b10:   pc_d = jmp_tgt;
      default: pc_d = EXC_VEC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     pc_q <= '0;
    else if (ld) pc_q <= pc_d;
  end
endmodule

// File: rtl/pc_update_unit_chk.sv
module pc_update_unit_chk #(
  parameter int unsigned W  = 32,
  parameter int unsigned JW = 26,
  parameter int unsigned IW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_uncond,
  input logic          wr_cond,
  input logic          alu_zero,
  input logic [1:0]    pc_sel,
  input logic [W-1:0]  alu_res,
  input logic [W-1:0]  alu_out_q,
  input logic [JW-1:0] jfield,
  input logic [IW-1:0] imm16,
  input logic [W-1:0]  pc,
  input logic [W-1:0]  br_off
);
  logic go;
  assign go = wr_uncond || (wr_cond && alu_zero);

  p_reset_r1: assert property (@(posedge clk) rst |=> (pc == '0));
  p_alu_r2: assert property (@(posedge clk) disable iff (rst)
    (go && pc_sel == 2'b00) |=> (pc == $past(alu_res)));
  p_br_r3: assert property (@(posedge clk) disable iff (rst)
    (go && pc_sel == 2'b01) |=> (pc == $past(alu_out_q)));
  p_jmp_r4: assert property (@(posedge clk) disable iff (rst)
    (go && pc_sel == 2'b10) |=> (pc[W-1 -: W-JW-2] == $past(pc[W-1 -: W-JW-2])
                                 && pc[JW+1:2] == $past(jfield) && pc[1:0] == 2'b00));
  p_exc_r5: assert property (@(posedge clk) disable iff (rst)
    (go && pc_sel == 2'b11) |=> (pc == 32'h8000_0180));
  p_nozero_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_cond && !alu_zero && !wr_uncond) |=> $stable(pc));
  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!wr_uncond && !wr_cond) |=> $stable(pc));
  p_or_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_uncond && wr_cond && !alu_zero && pc_sel == 2'b01) |=> (pc == $past(alu_out_q)));

  always @(posedge clk) begin
    if (!rst) begin
      p_off_r8: assert ($signed(br_off) == $signed(imm16) * 4 && br_off[1:0] == 2'b00);
    end
  end
endmodule

bind pc_update_unit pc_update_unit_chk #(.W(W), .JW(JW), .IW(IW)) chk_i (.*);

// File: tb/pc_update_unit_tb_top.sv
module pc_update_unit_tb_top;
  localparam int PERIOD = 10;

  typedef struct {
    logic [31:0] pc;
    logic [31:0] off;
    string       tag;
  } item_t;

  logic        clk = 0, rst = 1, wr_uncond = 0, wr_cond = 0, alu_zero = 0;
  logic [1:0]  pc_sel = 0;
  logic [31:0] alu_res = 0, alu_out_q = 0, pc, br_off;
  logic [25:0] jfield = 0;
  logic [15:0] imm16 = 0;

  item_t       q[$];
  logic [31:0] model = 0;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #(PERIOD/2) clk = ~clk;

  pc_update_unit dut_i (.clk, .rst, .wr_uncond, .wr_cond, .alu_zero, .pc_sel,
                        .alu_res, .alu_out_q, .jfield, .imm16, .pc, .br_off);

  task automatic step(input bit r, input bit u, input bit c, input bit z,
                      input logic [1:0] s, input logic [31:0] a, input logic [31:0] b,
                      input logic [25:0] j, input logic [15:0] im, input string tag);
    item_t it;
    @(negedge clk);
    rst = r; wr_uncond = u; wr_cond = c; alu_zero = z; pc_sel = s;
    alu_res = a; alu_out_q = b; jfield = j; imm16 = im;
    if (r) model = 0;
    else if (u || (c && z)) begin
      case (s)
        2'b00: model = a;
        2'b01: model = b;
        2'b10: model = {model[31:28], j, 2'b00};
        default: model = 32'h8000_0180;
      endcase
    end
    it.pc = model;
    it.off = 32'(int'($signed(im)) * 4);
    it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #(PERIOD/4);
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      total++;
      if (pc !== it.pc) begin
        bad++;
        $display("FAIL %s pc: actual=%h expected=%h", it.tag, pc, it.pc);
      end
      total++;
      if (br_off !== it.off) begin
        bad++;
        $display("FAIL %s (R8) br_off: actual=%h expected=%h", it.tag, br_off, it.off);
      end
    end
  end

  initial begin
    step(1, 1, 0, 0, 2'b00, 32'h1234_5678, 0, 0, 16'h0001, "R1 reset wins");
    step(0, 1, 0, 0, 2'b00, 32'h0000_0004, 0, 0, 16'hFFFF, "R2 alu load");
    step(0, 0, 0, 1, 2'b01, 32'hDEAD_BEEF, 32'h5555_0000, 0, 16'h7FFF, "R7 idle hold");
    step(0, 1, 0, 0, 2'b01, 0, 32'h0000_0100, 0, 16'h8000, "R3 branch reg load");
    step(0, 0, 1, 1, 2'b01, 0, 32'h0000_0200, 0, 16'h0010, "R6 cond taken");
    step(0, 0, 1, 0, 2'b01, 0, 32'h0000_0300, 0, 16'hFFF0, "R6 cond not taken");
    step(0, 1, 0, 0, 2'b00, 32'hA000_0010, 0, 0, 0, "R2 high nibble");
    step(0, 1, 0, 0, 2'b10, 32'h1111_1111, 0, 26'h3FF_FFFF, 0, "R4 jump keeps top");
    step(0, 1, 0, 0, 2'b10, 0, 0, 26'h000_0001, 16'h4000, "R4 jump small");
    step(0, 0, 0, 0, 2'b11, 0, 0, 0, 16'h1234, "R7 idle with exc sel");
    step(0, 1, 0, 0, 2'b11, 0, 0, 0, 0, "R5 exception vector");
    step(0, 1, 1, 0, 2'b01, 0, 32'h0000_0ABC, 0, 0, "R9 uncond overrides zero=0");
    step(0, 0, 1, 1, 2'b10, 0, 0, 26'h123_4567, 0, "R6 cond jump");
    step(1, 0, 0, 0, 2'b00, 0, 0, 0, 16'hC000, "R1 second reset");
    step(0, 0, 1, 0, 2'b00, 32'hFFFF_FFFC, 0, 0, 0, "R6 hold after reset");
    step(0, 1, 0, 0, 2'b00, 32'hFFFF_FFFC, 0, 0, 16'h0002, "R2 final");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule